// File: doc/BRIEF.md
# I2C Receive Byte Queue with Threshold Status

This block buffers bytes that an I2C byte engine has received until software drains them. The engine strobes each received byte in; software pops bytes one at a time and sees the oldest byte on the read-data output in the cycle after the pop. The block reports how many bytes it holds and keeps a sticky threshold flag. The flag sets only when the occupancy climbs up to a programmable threshold, and software clears it by writing a one.

Two outputs tell the engine what to do. A hold request asks the engine to keep SCL low while the queue sits at the threshold or is full, and it drops as soon as a pop frees space. When the last-byte option is enabled, a NACK indication tells the engine that the next byte it receives will complete the group and must be answered with NACK rather than ACK. A flush input discards all content. A sticky full flag records that the queue has filled.

Top module: `i2c_rx_stage`

## Requirements
- R1: After reset the occupancy is 0, the read data is 0x00, and the threshold flag, full flag, hold request and NACK indication are all 0.
- R2: Bytes come out in the order they were accepted. The popped byte appears on the read data one clock after the pop.
- R3: The occupancy goes up by one for each accepted byte and down by one for each pop of a non-empty queue. A push and a pop in the same cycle leave it unchanged.
- R4: The occupancy never exceeds DEPTH (32 by default). A byte offered to a full queue without a simultaneous pop is discarded.
- R5: A pop of an empty queue leaves the read data at its previous value and the occupancy at 0.
- R6: The threshold flag sets only when the occupancy changes from below a non-zero threshold to equal to it. Changing the threshold to match the current occupancy does not set it.
- R7: A one on the threshold-clear input clears the flag. If a new upward crossing happens in the same cycle, the flag stays set.
- R8: The hold request is 1 exactly while the occupancy equals a non-zero threshold or equals DEPTH, and it falls once a pop moves the occupancy off those values.
- R9: With the last-byte option enabled, the NACK indication is 1 while occupancy plus one equals a non-zero threshold. With the option disabled it is 0.
- R10: A flush sets the occupancy to 0 on the next clock and discards all stored bytes, so the next byte accepted is the next byte read.
- R11: The full flag sets when the occupancy rises to DEPTH. It is cleared by a one on the full-clear input, and a rise in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Engine strobe: a received byte is present |
| in_byte | input | DW | Received byte |
| pop | input | 1 | Software read strobe, removes the oldest byte |
| flush | input | 1 | Discards all content |
| thr | input | CW | Threshold level (0 disables threshold behaviour) |
| last_en | input | 1 | Enables NACK on the byte that completes the group |
| thr_clr | input | 1 | Write-one clear of the threshold flag |
| fe_clr | input | 1 | Write-one clear of the full flag |
| rd_byte | output | DW | Byte removed by the most recent successful pop |
| level | output | CW | Occupancy, 0 to DEPTH |
| thr_hit | output | 1 | Sticky threshold-reached flag |
| fe_flag | output | 1 | Sticky full flag |
| hold_scl | output | 1 | Request to the engine to keep SCL low |
| nack_next | output | 1 | The next received byte must be answered with NACK |

## Verification
The bench uses the default DEPTH of 32 and DW of 8. With these values the threshold field spans 0 to 32, and filling the queue takes 32 pushes. That makes the full boundary, the overflow discard and a complete drain all reachable in a few hundred cycles, together with threshold crossings at small levels. A queue model in the bench tracks every accepted byte and checks the occupancy on every clock, so simultaneous push/pop, flush and full-queue cases are all compared against it.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  // Bits needed to hold a count from 0 to d inclusive.
  function automatic int unsigned cnt_bits(input int unsigned d);
    return $clog2(d + 1);
  endfunction

  // Bits needed to address d entries (at least one).
  function automatic int unsigned addr_bits(input int unsigned d);
    return (d > 1) ? $clog2(d) : 1;
  endfunction
endpackage

// File: rtl/rxs_store.sv
module rxs_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // Write port, no reset, so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port; output holds between reads.
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxs_level.sv
module rxs_level #(
  parameter int DEPTH = 32,
  parameter int CW    = 6,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          flush,
  input  logic [CW-1:0] thr,
  input  logic          last_en,
  input  logic          thr_clr,
  input  logic          fe_clr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] level,
  output logic          thr_hit,
  output logic          fe_flag,
  output logic          hold_scl,
  output logic          nack_next
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [AW-1:0] wp_q, rp_q, wp_n, rp_n;
  logic [CW-1:0] lvl_q, lvl_d;
  logic          thr_q, fe_q, hold_q, nack_q;
  logic          do_pop, do_push, thr_rise, fe_rise;

  // Pointer advance: free wrap for power-of-two depths, compare otherwise.
  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wp_n = wp_q + AW'(1);
      assign rp_n = rp_q + AW'(1);
    end else begin : g_wrap
      assign wp_n = (wp_q == LAST_IDX) ? '0 : wp_q + AW'(1);
      assign rp_n = (rp_q == LAST_IDX) ? '0 : rp_q + AW'(1);
    end
  endgenerate

  assign do_pop  = pop_req && (lvl_q != '0) && !flush;
  assign do_push = push_req && !flush && ((lvl_q != FULL_LVL) || do_pop);

  always_comb begin
    lvl_d = lvl_q;
    if (flush)                 lvl_d = '0;
    else if (do_push && !do_pop) lvl_d = lvl_q + CW'(1);
    else if (do_pop && !do_push) lvl_d = lvl_q - CW'(1);
  end

  assign thr_rise = (thr != '0) && (lvl_q < thr) && (lvl_d == thr);
  assign fe_rise  = (lvl_q != FULL_LVL) && (lvl_d == FULL_LVL);

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q   <= '0;
      rp_q   <= '0;
      lvl_q  <= '0;
      thr_q  <= 1'b0;
      fe_q   <= 1'b0;
      hold_q <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      if (flush) begin
        wp_q <= '0;
        rp_q <= '0;
      end else begin
        if (do_push) wp_q <= wp_n;
        if (do_pop)  rp_q <= rp_n;
      end
      lvl_q  <= lvl_d;
      thr_q  <= thr_rise | (thr_q & ~thr_clr);
      fe_q   <= fe_rise | (fe_q & ~fe_clr);
      hold_q <= ((thr != '0) && (lvl_d == thr)) || (lvl_d == FULL_LVL);
      nack_q <= last_en && (thr != '0) && ((lvl_d + CW'(1)) == thr);
    end
  end

  assign wr_en     = do_push;
  assign wr_addr   = wp_q;
  assign rd_en     = do_pop;
  assign rd_addr   = rp_q;
  assign level     = lvl_q;
  assign thr_hit   = thr_q;
  assign fe_flag   = fe_q;
  assign hold_scl  = hold_q;
  assign nack_next = nack_q;
endmodule

// File: rtl/i2c_rx_stage.sv
module i2c_rx_stage #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int CW    = rxs_pkg::cnt_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_byte,
  input  logic          pop,
  input  logic          flush,
  input  logic [CW-1:0] thr,
  input  logic          last_en,
  input  logic          thr_clr,
  input  logic          fe_clr,
  output logic [DW-1:0] rd_byte,
  output logic [CW-1:0] level,
  output logic          thr_hit,
  output logic          fe_flag,
  output logic          hold_scl,
  output logic          nack_next
);
  localparam int AW = rxs_pkg::addr_bits(DEPTH);

  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;

  rxs_level #(.DEPTH(DEPTH), .CW(CW), .AW(AW)) u_level (
    .clk      (clk),
    .rst      (rst),
    .push_req (in_valid),
    .pop_req  (pop),
    .flush    (flush),
    .thr      (thr),
    .last_en  (last_en),
    .thr_clr  (thr_clr),
    .fe_clr   (fe_clr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .level    (level),
    .thr_hit  (thr_hit),
    .fe_flag  (fe_flag),
    .hold_scl (hold_scl),
    .nack_next(nack_next)
  );

  rxs_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
    .clk  (clk),
    .rst  (rst),
    .we   (wr_en),
    .waddr(wr_addr),
    .wdata(in_byte),
    .re   (rd_en),
    .raddr(rd_addr),
    .rdata(rd_byte)
  );
endmodule

// File: rtl/i2c_rx_stage_chk.sv
module i2c_rx_stage_chk #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          pop,
  input logic          flush,
  input logic [CW-1:0] thr,
  input logic [CW-1:0] level,
  input logic [DW-1:0] rd_byte,
  input logic          hold_scl,
  input logic          thr_hit
);
  assert_level_bound_R4: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (level == '0));

  assert_hold_match_R8: assert property (@(posedge clk) disable iff (rst)
    hold_scl |-> (((level == $past(thr)) && ($past(thr) != '0)) || (level == CW'(DEPTH))));

  assert_rise_upward_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(thr_hit) |-> ((level == $past(thr)) && ($past(level) < $past(thr))));

  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (rst)
    (pop && (level == '0) && !in_valid && !flush) |=> ($stable(rd_byte) && (level == '0)));

  assert_pushpop_even_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pop && (level != '0) && !flush) |=> $stable(level));
endmodule

bind i2c_rx_stage i2c_rx_stage_chk #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_valid(in_valid),
  .pop     (pop),
  .flush   (flush),
  .thr     (thr),
  .level   (level),
  .rd_byte (rd_byte),
  .hold_scl(hold_scl),
  .thr_hit (thr_hit)
);

// File: tb/i2c_rx_stage_test.sv
module i2c_rx_stage_test;
  localparam int DEPTH = 32;
  localparam int DW    = 8;
  localparam int CW    = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0, pop = 1'b0, flush = 1'b0;
  logic [DW-1:0] in_byte = '0;
  logic [CW-1:0] thr = '0;
  logic          last_en = 1'b0, thr_clr = 1'b0, fe_clr = 1'b0;
  logic [DW-1:0] rd_byte;
  logic [CW-1:0] level;
  logic          thr_hit, fe_flag, hold_scl, nack_next;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  always #5 clk = ~clk;

  i2c_rx_stage #(.DEPTH(DEPTH), .DW(DW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .pop(pop),
    .flush(flush), .thr(thr), .last_en(last_en), .thr_clr(thr_clr),
    .fe_clr(fe_clr), .rd_byte(rd_byte), .level(level), .thr_hit(thr_hit),
    .fe_flag(fe_flag), .hold_scl(hold_scl), .nack_next(nack_next)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: one clock of stimulus, called at a falling edge.
  task automatic cyc(input bit v, input logic [DW-1:0] b, input bit p,
                     input bit f, input bit tc, input bit fc);
    in_valid = v; in_byte = b; pop = p; flush = f; thr_clr = tc; fe_clr = fc;
    @(negedge clk);
    in_valid = 0; pop = 0; flush = 0; thr_clr = 0; fe_clr = 0;
  endtask

  // Scoreboard: expected bytes queued by the driver side, popped and
  // compared by this monitor as the design produces them.
  logic [DW-1:0] model[$];
  logic [DW-1:0] expb;
  bit            pp, ps;

  always @(posedge clk) begin
    if (rst) model.delete();
    else begin
      pp = 0;
      if (flush) model.delete();
      else begin
        pp = pop && (model.size() > 0);
        ps = in_valid && ((model.size() < DEPTH) || pp);
        if (pp) expb = model.pop_front();
        if (ps) model.push_back(in_byte);
      end
      #2;
      if (pp) chk("R2 order", int'(rd_byte), int'(expb));
      chk("R3 level", int'(level), model.size());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 level", int'(level), 0);
    chk("R1 rd_byte", int'(rd_byte), 0);
    chk("R1 flags", int'({thr_hit, fe_flag, hold_scl, nack_next}), 0);

    thr = 6'd4; last_en = 1;
    cyc(0, 8'h00, 0, 0, 0, 0);
    chk("R9 nack at level 0", int'(nack_next), 0);
    cyc(1, 8'h11, 0, 0, 0, 0);
    cyc(1, 8'h22, 0, 0, 0, 0);
    cyc(1, 8'h33, 0, 0, 0, 0);
    chk("R9 nack at thr-1", int'(nack_next), 1);
    chk("R6 no flag below thr", int'(thr_hit), 0);
    cyc(1, 8'h44, 0, 0, 0, 0);
    chk("R6 flag on crossing", int'(thr_hit), 1);
    chk("R8 hold at thr", int'(hold_scl), 1);
    chk("R9 nack off at thr", int'(nack_next), 0);
    cyc(0, 8'h00, 0, 0, 1, 0);
    chk("R7 write-one clear", int'(thr_hit), 0);
    cyc(0, 8'h00, 1, 0, 0, 0);
    chk("R8 hold released by pop", int'(hold_scl), 0);
    cyc(1, 8'h55, 0, 0, 1, 0);
    chk("R7 set wins over clear", int'(thr_hit), 1);
    cyc(0, 8'h00, 0, 0, 1, 0);
    cyc(0, 8'h00, 1, 0, 0, 0);
    thr = 6'd3;
    cyc(0, 8'h00, 0, 0, 0, 0);
    chk("R6 no flag on thr change", int'(thr_hit), 0);
    chk("R8 hold at new thr", int'(hold_scl), 1);
    last_en = 0; thr = 6'd4;
    cyc(0, 8'h00, 0, 0, 0, 0);
    chk("R9 nack disabled", int'(nack_next), 0);
    cyc(1, 8'h66, 1, 0, 0, 0);
    chk("R3 push+pop level", int'(level), 3);

    // R10 flush
    cyc(0, 8'h00, 0, 1, 0, 0);
    chk("R10 level after flush", int'(level), 0);
    cyc(1, 8'hA5, 0, 0, 0, 0);
    cyc(0, 8'h00, 1, 0, 0, 0);
    chk("R10 first byte after flush", int'(rd_byte), 8'hA5);

    // R4 / R11 fill to capacity
    thr = 6'd0;
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'(i * 3 + 1), 0, 0, 0, 0);
    chk("R4 full level", int'(level), DEPTH);
    chk("R11 full flag", int'(fe_flag), 1);
    chk("R8 hold when full", int'(hold_scl), 1);
    cyc(1, 8'hEE, 0, 0, 0, 0);
    chk("R4 overflow dropped", int'(level), DEPTH);
    cyc(0, 8'h00, 0, 0, 0, 1);
    chk("R11 full flag cleared", int'(fe_flag), 0);
    for (int i = 0; i < DEPTH; i++) cyc(0, 8'h00, 1, 0, 0, 0);
    chk("R8 hold off when empty", int'(hold_scl), 0);

    // R5 pop of empty queue
    cyc(0, 8'h00, 1, 0, 0, 0);
    chk("R5 rd_byte held", int'(rd_byte), (DEPTH - 1) * 3 + 1);
    chk("R5 level stays 0", int'(level), 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule